// File: doc/BRIEF.md
# Bootstrap Refresh Enforcer

This block sits in the gate-command path between a PWM source and the shoot-through interlock of a half-bridge whose high side is biased from a bootstrap capacitor. That capacitor only recharges while the switch node is held low, which means while the low side conducts. A command stream that keeps the high side on for a long time, or one that stays quiet for a long time, would let the floating bias drain. The enforcer watches both cases and inserts a short recharge window when either one runs too long.

Two running measures are kept, both counted in clock cycles. The first is how long the high-side command has been continuously on. The second is how long it has been since the last recharge interval of useful length. A low-side command held for at least the programmed recharge length counts as a full recharge and clears both measures. A shorter low-side interval clears neither.

When either measure reaches its limit, the block takes over the outputs. It first turns the high side off and holds a dead gap. It then drives the low side alone for the programmed recharge length, holds a second dead gap, and returns to pass-through. At that point the high side comes back only if it is still commanded. Every inserted window raises a one-cycle status pulse and advances a saturating event count.

Top module: `brf_enforcer`

## Requirements
- R1: After reset the block is in pass-through, `refresh_pulse_o` is 0 and `refresh_count_o` is 0.
- R2: While no limit is reached, `hs_o` equals `hs_cmd_i` and `ls_o` equals `ls_cmd_i` in the same cycle.
- R3: `hs_o` is never high for more than `max_on_i` consecutive cycles. When the high-side command has been on for `max_on_i` pass-through cycles, a forced window starts in the next cycle.
- R4: A forced window has three phases in this order: DEAD_CYC cycles with both outputs 0, then `refresh_len_i` cycles with `ls_o`=1 and `hs_o`=0, then DEAD_CYC cycles with both outputs 0. Pass-through resumes after the last of these.
- R5: When `max_idle_i` pass-through cycles go by without a qualifying recharge, a forced window is inserted, even if both commands are low.
- R6: A low-side command held for at least `refresh_len_i` consecutive pass-through cycles clears both the on-time measure and the idle measure.
- R7: A low-side command interval shorter than `refresh_len_i` clears neither measure. It does not postpone the idle-triggered window.
- R8: `refresh_pulse_o` is high for exactly one cycle per forced window, in the window's first dead cycle.
- R9: `refresh_count_o` rises by one at each forced window, visible in that window's first cycle, and stops at its all-ones value.
- R10: During a forced window both command inputs have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_cmd_i | input | 1 | High-side command from the PWM source |
| ls_cmd_i | input | 1 | Low-side command from the PWM source |
| max_on_i | input | CNT_W | Longest allowed continuous high-side on-time, in cycles (at least 1) |
| max_idle_i | input | CNT_W | Longest allowed span without a recharge, in cycles (at least 1) |
| refresh_len_i | input | LEN_W | Minimum recharge length, in cycles (at least 1) |
| hs_o | output | 1 | High-side command to the interlock |
| ls_o | output | 1 | Low-side command to the interlock |
| refresh_pulse_o | output | 1 | One-cycle pulse at the start of each forced window |
| refresh_count_o | output | EVT_W | Saturating count of forced windows |

## Verification
Some properties are checked on every cycle. `hs_o` never runs past the on-time limit. It is never high unless commanded. A low-side output with no low-side command never coincides with the high side on. The status pulse lasts one cycle and falls in a dead cycle, and the event count changes only with that pulse. The phase lengths of a forced window, the clearing by long low-side intervals, and the absence of clearing by short ones are shown only by the bench scenarios. The same holds for idle-driven insertion and count saturation. In those scenarios a cycle-level model of the requirements predicts every output.

// File: rtl/brf_pkg.sv
package brf_pkg;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_GAP_IN  = 2'd1,
        ST_REFRESH = 2'd2,
        ST_GAP_OUT = 2'd3
    } brf_state_e;

endpackage

// File: rtl/brf_activity_tracker.sv
module brf_activity_tracker #(
    parameter int CNT_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass_i,
    input  logic             hs_cmd_i,
    input  logic             ls_cmd_i,
    input  logic [CNT_W-1:0] max_on_i,
    input  logic [CNT_W-1:0] max_idle_i,
    input  logic [LEN_W-1:0] refresh_len_i,
    output logic             force_o
);

    typedef struct packed {
        logic [LEN_W-1:0] low_run;
        logic [CNT_W-1:0] on_run;
        logic [CNT_W-1:0] idle_run;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [LEN_W-1:0] low_inc;
    logic [CNT_W-1:0] on_nxt;
    logic [CNT_W-1:0] idle_nxt;
    logic             qualified;
    logic             force_c;

    always_comb begin
        low_inc   = (trk_q.low_run == '1) ? trk_q.low_run : trk_q.low_run + 1'b1;
        qualified = pass_i && ls_cmd_i && (low_inc >= refresh_len_i);

        if (qualified) begin
            on_nxt = '0;
        end else if (hs_cmd_i) begin
            on_nxt = (trk_q.on_run == '1) ? trk_q.on_run : trk_q.on_run + 1'b1;
        end else begin
            on_nxt = '0;
        end

        if (qualified) begin
            idle_nxt = '0;
        end else begin
            idle_nxt = (trk_q.idle_run == '1) ? trk_q.idle_run : trk_q.idle_run + 1'b1;
        end

        force_c = pass_i && ((on_nxt >= max_on_i) || (idle_nxt >= max_idle_i));

        trk_d = trk_q;
        if (!pass_i || force_c) begin
            trk_d.low_run  = '0;
            trk_d.on_run   = '0;
            trk_d.idle_run = '0;
        end else begin
            trk_d.low_run  = ls_cmd_i ? low_inc : '0;
            trk_d.on_run   = on_nxt;
            trk_d.idle_run = idle_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign force_o = force_c;

endmodule

// File: rtl/brf_sequencer.sv
module brf_sequencer
    import brf_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int DEAD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_i,
    input  logic             hs_cmd_i,
    input  logic             ls_cmd_i,
    input  logic [LEN_W-1:0] refresh_len_i,
    output logic             hs_o,
    output logic             ls_o,
    output logic             pass_o,
    output logic             start_o
);

    localparam int DEAD_W = $clog2(DEAD_CYC + 1);
    localparam int TMR_W  = (LEN_W > DEAD_W) ? LEN_W : DEAD_W;
    localparam logic [TMR_W-1:0] DEAD_LAST = TMR_W'(DEAD_CYC - 1);

    typedef struct packed {
        brf_state_e       st;
        logic [TMR_W-1:0] tmr;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [TMR_W:0] tmr_inc;
    logic [TMR_W:0] len_ext;

    always_comb begin
        tmr_inc = {1'b0, seq_q.tmr} + 1'b1;
        len_ext = {1'b0, TMR_W'(refresh_len_i)};
        seq_d   = seq_q;

        case (seq_q.st)
            ST_PASS: begin
                if (force_i) begin
                    seq_d.st  = ST_GAP_IN;
                    seq_d.tmr = '0;
                end
            end
            ST_GAP_IN: begin
                if (seq_q.tmr == DEAD_LAST) begin
                    seq_d.st  = ST_REFRESH;
                    seq_d.tmr = '0;
                end else begin
                    seq_d.tmr = tmr_inc[TMR_W-1:0];
                end
            end
            ST_REFRESH: begin
                if (tmr_inc >= len_ext) begin
                    seq_d.st  = ST_GAP_OUT;
                    seq_d.tmr = '0;
                end else begin
                    seq_d.tmr = tmr_inc[TMR_W-1:0];
                end
            end
            ST_GAP_OUT: begin
                if (seq_q.tmr == DEAD_LAST) begin
                    seq_d.st  = ST_PASS;
                    seq_d.tmr = '0;
                end else begin
                    seq_d.tmr = tmr_inc[TMR_W-1:0];
                end
            end
            default: begin
                seq_d.st  = ST_PASS;
                seq_d.tmr = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_PASS;
            seq_q.tmr <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pass_o  = (seq_q.st == ST_PASS);
    assign hs_o    = pass_o && hs_cmd_i;
    assign ls_o    = pass_o ? ls_cmd_i : (seq_q.st == ST_REFRESH);
    assign start_o = (seq_q.st == ST_GAP_IN) && (seq_q.tmr == '0);

endmodule

// File: rtl/brf_event_counter.sv
module brf_event_counter #(
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [EVT_W-1:0] count_o
);

    logic [EVT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/brf_enforcer.sv
module brf_enforcer #(
    parameter int CNT_W    = 16,
    parameter int LEN_W    = 8,
    parameter int DEAD_CYC = 4,
    parameter int EVT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_cmd_i,
    input  logic             ls_cmd_i,
    input  logic [CNT_W-1:0] max_on_i,
    input  logic [CNT_W-1:0] max_idle_i,
    input  logic [LEN_W-1:0] refresh_len_i,
    output logic             hs_o,
    output logic             ls_o,
    output logic             refresh_pulse_o,
    output logic [EVT_W-1:0] refresh_count_o
);

    logic pass_w;
    logic force_w;

    brf_activity_tracker #(
        .CNT_W(CNT_W),
        .LEN_W(LEN_W)
    ) tracker_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pass_i       (pass_w),
        .hs_cmd_i     (hs_cmd_i),
        .ls_cmd_i     (ls_cmd_i),
        .max_on_i     (max_on_i),
        .max_idle_i   (max_idle_i),
        .refresh_len_i(refresh_len_i),
        .force_o      (force_w)
    );

    brf_sequencer #(
        .LEN_W   (LEN_W),
        .DEAD_CYC(DEAD_CYC)
    ) sequencer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_i      (force_w),
        .hs_cmd_i     (hs_cmd_i),
        .ls_cmd_i     (ls_cmd_i),
        .refresh_len_i(refresh_len_i),
        .hs_o         (hs_o),
        .ls_o         (ls_o),
        .pass_o       (pass_w),
        .start_o      (refresh_pulse_o)
    );

    brf_event_counter #(
        .EVT_W(EVT_W)
    ) events_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (force_w),
        .count_o(refresh_count_o)
    );

endmodule

// File: rtl/brf_enforcer_checker.sv
module brf_enforcer_checker #(
    parameter int CNT_W = 16,
    parameter int EVT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_cmd_i,
    input logic             ls_cmd_i,
    input logic [CNT_W-1:0] max_on_i,
    input logic             hs_o,
    input logic             ls_o,
    input logic             refresh_pulse_o,
    input logic [EVT_W-1:0] refresh_count_o
);

    logic [CNT_W:0] hs_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_run_q <= '0;
        end else if (!hs_o) begin
            hs_run_q <= '0;
        end else if (hs_run_q != '1) begin
            hs_run_q <= hs_run_q + 1'b1;
        end
    end

    // R3: the high-side output never exceeds the on-time limit
    p_on_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_o |-> (hs_run_q < {1'b0, max_on_i}));

    // R2 and R10: the high side is never driven without a command
    p_hs_needs_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hs_o |-> hs_cmd_i);

    // R4: a forced low side never coincides with the high side
    p_forced_ls_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_o && !ls_cmd_i) |-> !hs_o);

    // R8: the status pulse falls in a dead cycle
    p_pulse_dead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse_o |-> (!hs_o && !ls_o));

    // R8: the status pulse lasts one cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse_o |=> !refresh_pulse_o);

    // R9: the count steps by one with each pulse until it saturates
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_pulse_o && ($past(refresh_count_o) != '1))
            |-> (refresh_count_o == $past(refresh_count_o) + 1'b1));

    // R9: the count holds when no window starts
    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_pulse_o |-> (refresh_count_o == $past(refresh_count_o)));

endmodule

bind brf_enforcer brf_enforcer_checker #(
    .CNT_W(CNT_W),
    .EVT_W(EVT_W)
) checker_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .hs_cmd_i       (hs_cmd_i),
    .ls_cmd_i       (ls_cmd_i),
    .max_on_i       (max_on_i),
    .hs_o           (hs_o),
    .ls_o           (ls_o),
    .refresh_pulse_o(refresh_pulse_o),
    .refresh_count_o(refresh_count_o)
);

// File: tb/brf_enforcer_tb_top.sv
module brf_enforcer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int LEN_W      = 8;
    localparam int DEAD_CYC   = 2;
    localparam int EVT_W      = 3;
    localparam int MAX_ON     = 6;
    localparam int MAX_IDLE   = 20;
    localparam int RLEN       = 3;
    localparam int CNT_SAT    = (1 << EVT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hs_cmd = 1'b0;
    logic             ls_cmd = 1'b0;
    logic [CNT_W-1:0] max_on = CNT_W'(MAX_ON);
    logic [CNT_W-1:0] max_idle = CNT_W'(MAX_IDLE);
    logic [LEN_W-1:0] rlen = LEN_W'(RLEN);
    logic             hs_out;
    logic             ls_out;
    logic             pulse_out;
    logic [EVT_W-1:0] count_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic  hs;
        logic  ls;
        logic  pulse;
        int    count;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // Requirement model: mode 0 pass-through, 1 entry gap, 2 recharge, 3 exit gap
    int m_mode, m_phase, m_on, m_since, m_low, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    brf_enforcer #(
        .CNT_W   (CNT_W),
        .LEN_W   (LEN_W),
        .DEAD_CYC(DEAD_CYC),
        .EVT_W   (EVT_W)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .hs_cmd_i       (hs_cmd),
        .ls_cmd_i       (ls_cmd),
        .max_on_i       (max_on),
        .max_idle_i     (max_idle),
        .refresh_len_i  (rlen),
        .hs_o           (hs_out),
        .ls_o           (ls_out),
        .refresh_pulse_o(pulse_out),
        .refresh_count_o(count_out)
    );

    task automatic step(input logic h, input logic l, input string tag);
        exp_t e;
        @(negedge clk);
        hs_cmd = h;
        ls_cmd = l;
        e.tag   = tag;
        e.count = m_cnt;
        e.pulse = (m_mode == 1) && (m_phase == 0);
        e.hs    = (m_mode == 0) ? h : 1'b0;
        e.ls    = (m_mode == 0) ? l : (m_mode == 2);
        exp_q.push_back(e);
        case (m_mode)
            0: begin
                m_low = l ? m_low + 1 : 0;
                if (l && m_low >= RLEN) begin
                    m_on    = 0;
                    m_since = 0;
                end else begin
                    m_on    = h ? m_on + 1 : 0;
                    m_since = m_since + 1;
                end
                if (m_on >= MAX_ON || m_since >= MAX_IDLE) begin
                    m_mode  = 1;
                    m_phase = 0;
                    m_on    = 0;
                    m_since = 0;
                    m_low   = 0;
                    if (m_cnt < CNT_SAT) m_cnt = m_cnt + 1;
                end
            end
            1, 3: begin
                m_phase = m_phase + 1;
                if (m_phase == DEAD_CYC) begin
                    m_mode  = (m_mode == 1) ? 2 : 0;
                    m_phase = 0;
                end
            end
            default: begin
                m_phase = m_phase + 1;
                if (m_phase == RLEN) begin
                    m_mode  = 3;
                    m_phase = 0;
                end
            end
        endcase
    endtask

    task automatic repeat_step(input logic h, input logic l, input int n, input string tag);
        for (int i = 0; i < n; i++) step(h, l, tag);
    endtask

    task automatic pwm(input int hs_len, input int ls_len, input int periods, input string tag);
        for (int p = 0; p < periods; p++) begin
            repeat_step(1'b1, 1'b0, hs_len, tag);
            repeat_step(1'b0, 1'b1, ls_len, tag);
        end
    endtask

    // Monitor: compares each expected item just before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/2 - 1);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (hs_out !== e.hs || ls_out !== e.ls || pulse_out !== e.pulse
                    || int'(count_out) != e.count) begin
                    errors++;
                    $display("FAIL %s: hs/ls/pulse/count actual %b/%b/%b/%0d expected %b/%b/%b/%0d",
                             e.tag, hs_out, ls_out, pulse_out, count_out,
                             e.hs, e.ls, e.pulse, e.count);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_mode = 0; m_phase = 0; m_on = 0; m_since = 0; m_low = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/2 - 1);
        checks++;
        if (count_out !== '0 || pulse_out !== 1'b0 || hs_out !== 1'b0 || ls_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset count/pulse/hs/ls actual %0d/%b/%b/%b expected 0/0/0/0",
                     count_out, pulse_out, hs_out, ls_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: pass-through straight after reset
        repeat_step(1'b0, 1'b1, 2, "R1");
        // R2: regular PWM with long low-side intervals passes unchanged
        pwm(2, 4, 5, "R2");
        // R3 and R4: long high-side hold gets windows of the right shape
        repeat_step(1'b1, 1'b0, 20, "R3");
        repeat_step(1'b0, 1'b1, 3, "R4");
        // R10: commands toggled during a forced window are ignored
        repeat_step(1'b1, 1'b0, 6, "R10");
        for (int i = 0; i < 8; i++) step(i[0], ~i[0], "R10");
        repeat_step(1'b0, 1'b1, 3, "R10");
        // R7: short low intervals do not hold off the idle window
        pwm(5, 2, 6, "R7");
        repeat_step(1'b0, 1'b1, 3, "R7");
        // R6: low intervals of full length keep both measures cleared
        pwm(5, 3, 6, "R6");
        // R5: idle with both commands low still receives windows
        repeat_step(1'b0, 1'b0, 50, "R5");
        // R8: pulses observed across back-to-back windows
        repeat_step(1'b1, 1'b0, 30, "R8");
        // R9: enough windows to drive the count into saturation
        repeat_step(1'b1, 1'b0, 120, "R9");
        repeat_step(1'b0, 1'b0, 4, "R9");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule